// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation cache that sits between an address generator and a page-table walker. A requester presents a virtual page number together with the identifier of the address space that is running. One clock later the block reports whether a matching translation is held. If one is, it also returns the physical frame number and whether the page may be written. A write access that hits a page marked read-only raises a fault flag in the same result.

After a miss, the walker, which lies outside this block, writes the translation it found through the fill port. Each entry carries its address-space tag, so translations from several processes can coexist and a context switch needs no flush. Software can still invalidate everything, or only the entries of one address space. Entries filled as pinned survive both kinds of flush and are never chosen for replacement. The table holds 16 entries by default. Page-number, frame-number and tag widths are parameters.

Top module: `xlat_cache`

## Requirements
- R1: A lookup presented with `lk_req` high produces `rs_valid` high exactly one clock later, and `rs_valid` is low in every other cycle. The result reflects the table as it stood before any fill or flush taken at the same clock edge.
- R2: A lookup hits only when one valid entry holds both the requested page number and the requested address-space tag. A hit returns that entry's frame number and writable bit. A miss returns frame 0 and writable 0.
- R3: `rs_fault` is high only when the lookup hit, `lk_write` was high, and the hit entry's writable bit is 0 (read-only). A read of a read-only page, or a write of a writable page, gives no fault.
- R4: A fill whose page number and tag both match a valid entry rewrites that entry in place: frame, writable bit and pinned bit. No other entry changes and the rotation pointer does not move.
- R5: A fill that matches no entry takes the lowest-numbered invalid entry if one exists, and leaves the rotation pointer unchanged.
- R6: When every entry is valid, a non-matching fill replaces the first unpinned entry found at or after the rotation pointer, searching upward with wrap-around. The pointer then moves to the entry after the victim. When every entry is pinned, the fill is dropped. Pinned entries always stay valid.
- R7: `inv_all` invalidates every unpinned entry and leaves pinned entries intact.
- R8: `inv_asid_en` invalidates only the unpinned entries whose tag equals `inv_asid`.
- R9: A fill in the same cycle as either flush is ignored. `inv_all` takes precedence over `inv_asid_en`.
- R10: Synchronous active-low reset empties the table, clears all pin marks, sets the rotation pointer to entry 0, and drives all result outputs to 0.
- R11: No two valid entries ever share the same page number and tag, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space tag of the requester |
| lk_write | input | 1 | The access is a write |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Translation found |
| rs_pfn | output | PFN_W | Physical frame number (0 on miss) |
| rs_writable | output | 1 | Hit page is writable (0 on miss) |
| rs_fault | output | 1 | Write to a read-only page |
| fl_en | input | 1 | Fill strobe |
| fl_vpn | input | VPN_W | Page number to install |
| fl_asid | input | ASID_W | Tag to install |
| fl_pfn | input | PFN_W | Frame number to install |
| fl_writable | input | 1 | Installed page is writable |
| fl_wired | input | 1 | Pin the installed entry |
| inv_all | input | 1 | Invalidate all unpinned entries |
| inv_asid_en | input | 1 | Invalidate unpinned entries of one tag |
| inv_asid | input | ASID_W | Tag for the selective flush |

## Verification
The hardest situation to reach from the ports is a full table that has a hole punched into it. That is the only state where the choice between the lowest free entry and the rotating victim is visible: a selective flush of a single-tag entry leaves the hole, and two more fills then show which entry each one displaced. A second hard case is a table full of pinned entries, where the fill must be dropped rather than evict anything. The bench builds both by filling all sixteen entries with chosen tags and pin marks, then flushing one tag. A long random phase over a deliberately small page and tag space keeps collisions, in-place rewrites, simultaneous fill and flush, and lookups that race a fill frequent, while a behavioural model checks every result.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package xlat_pkg;

    // How a fill finds its destination entry.
    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_MATCH  = 2'd1,
        FILL_FREE   = 2'd2,
        FILL_ROTATE = 2'd3
    } fill_kind_e;

endpackage

// File: rtl/xlat_match.sv
// Parallel tag comparator: flags every valid entry whose page number
// and address-space tag equal the key. Purely combinational.
// Assumes the caller keeps keys unique, so at most one bit is set.
module xlat_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
    input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
    input  logic [VPN_W-1:0]               key_vpn_i,
    input  logic [ASID_W-1:0]              key_asid_i,
    output logic [ENTRIES-1:0]             match_o
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g]
                          && (vpn_i[g] == key_vpn_i)
                          && (asid_i[g] == key_asid_i);
    end

endmodule

// File: rtl/xlat_victim.sv
// Replacement chooser: finds the lowest invalid entry, and separately
// the first unpinned entry at or after the rotation pointer (with wrap).
// Assumes pinned entries are always valid. Purely combinational.
module xlat_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] wired_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic               free_ok_o,
    output logic [IDX_W-1:0]   free_idx_o,
    output logic               rot_ok_o,
    output logic [IDX_W-1:0]   rot_idx_o
);

    // Lowest-numbered empty slot.
    always_comb begin
        free_ok_o  = 1'b0;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_ok_o  = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end

    // First unpinned slot scanning upward from the pointer.
    always_comb begin
        int pos;
        rot_ok_o  = 1'b0;
        rot_idx_o = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            pos = int'(rr_i) + k;
            if (pos >= ENTRIES) pos = pos - ENTRIES;
            if (!wired_i[IDX_W'(pos)]) begin
                rot_ok_o  = 1'b1;
                rot_idx_o = IDX_W'(pos);
            end
        end
    end

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation buffer with per-entry address-space tags,
// pinned entries, whole and per-tag flush, and a registered lookup result.
// Assumes: one lookup and at most one table command per cycle; a fill in
// the same cycle as a flush is dropped; flush-all beats per-tag flush.
module xlat_cache #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [PFN_W-1:0]  rs_pfn,
    output logic              rs_writable,
    output logic              rs_fault,
    input  logic              fl_en,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic              fl_writable,
    input  logic              fl_wired,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid
);
    import xlat_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             wired_q;
    logic [ENTRIES-1:0]             wr_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    logic [IDX_W-1:0]               rr_q;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic               lk_any;
    logic [PFN_W-1:0]   sel_pfn;
    logic               sel_wr;
    logic [IDX_W-1:0]   fm_idx;
    logic               free_ok, rot_ok;
    logic [IDX_W-1:0]   free_idx, rot_idx;
    fill_kind_e         fill_kind;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_go;

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cmp (
        .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
        .key_vpn_i(lk_vpn), .key_asid_i(lk_asid), .match_o(lk_match)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fl_cmp (
        .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
        .key_vpn_i(fl_vpn), .key_asid_i(fl_asid), .match_o(fl_match)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valid_i(valid_q), .wired_i(wired_q), .rr_i(rr_q),
        .free_ok_o(free_ok), .free_idx_o(free_idx),
        .rot_ok_o(rot_ok), .rot_idx_o(rot_idx)
    );

    // Merge the data of the (single) matching entry.
    always_comb begin
        lk_any  = |lk_match;
        sel_pfn = '0;
        sel_wr  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_pfn = sel_pfn | pfn_q[i];
                sel_wr  = sel_wr | wr_q[i];
            end
        end
    end

    // Encode the index of an entry the fill key already occupies.
    always_comb begin
        fm_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fl_match[i]) fm_idx = IDX_W'(i);
        end
    end

    // Decide where a fill lands: in place, a free slot, the rotating victim, or nowhere.
    always_comb begin
        fill_go = fl_en && !inv_all && !inv_asid_en;
        if (|fl_match) begin
            fill_kind = FILL_MATCH;
            fill_idx  = fm_idx;
        end else if (free_ok) begin
            fill_kind = FILL_FREE;
            fill_idx  = free_idx;
        end else if (rot_ok) begin
            fill_kind = FILL_ROTATE;
            fill_idx  = rot_idx;
        end else begin
            fill_kind = FILL_NONE;
            fill_idx  = '0;
        end
    end

    // Register the lookup result one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid    <= 1'b0;
            rs_hit      <= 1'b0;
            rs_pfn      <= '0;
            rs_writable <= 1'b0;
            rs_fault    <= 1'b0;
        end else begin
            rs_valid    <= lk_req;
            rs_hit      <= lk_req && lk_any;
            rs_pfn      <= (lk_req && lk_any) ? sel_pfn : '0;
            rs_writable <= lk_req && lk_any && sel_wr;
            rs_fault    <= lk_req && lk_any && lk_write && !sel_wr;
        end
    end

    // Apply flushes or a fill to the entry table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            wired_q <= '0;
            wr_q    <= '0;
            vpn_q   <= '0;
            asid_q  <= '0;
            pfn_q   <= '0;
            rr_q    <= '0;
        end else if (inv_all) begin
            valid_q <= valid_q & wired_q;
        end else if (inv_asid_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!wired_q[i] && asid_q[i] == inv_asid) valid_q[i] <= 1'b0;
            end
        end else if (fill_go && fill_kind != FILL_NONE) begin
            valid_q[fill_idx] <= 1'b1;
            wired_q[fill_idx] <= fl_wired;
            wr_q[fill_idx]    <= fl_writable;
            vpn_q[fill_idx]   <= fl_vpn;
            asid_q[fill_idx]  <= fl_asid;
            pfn_q[fill_idx]   <= fl_pfn;
            if (fill_kind == FILL_ROTATE) begin
                rr_q <= (fill_idx == IDX_W'(ENTRIES - 1)) ? '0 : fill_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for xlat_cache, attached by bind below.
// Assumes it observes the entry state vectors and the lookup match vector.
module xlat_cache_chk #(
    parameter int ENTRIES = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_writable,
    input logic               rs_fault,
    input logic               inv_all,
    input logic [ENTRIES-1:0] lk_match,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] wired_q
);

    a_r1_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rs_valid);

    a_r1_no_stray_result: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rs_valid);

    a_r2_miss_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> !rs_writable);

    a_r3_fault_on_ro_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> (rs_valid && rs_hit && !rs_writable));

    a_r6_wired_resident: assert property (@(posedge clk) disable iff (!rst_n)
        (wired_q & ~valid_q) == '0);

    a_r7_flush_keeps_wired: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> ((valid_q & ~wired_q) == '0));

    a_r11_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_writable(rs_writable), .rs_fault(rs_fault),
    .inv_all(inv_all), .lk_match(lk_match), .valid_q(valid_q), .wired_q(wired_q)
);

// File: tb/xlat_cache_tb.sv
// Self-checking bench: behavioural table model compared every clock,
// plus directed scenarios with hand-computed expectations.
module xlat_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int VW = 20, PW = 20, AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, lk_write = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic rs_valid, rs_hit, rs_writable, rs_fault;
    logic [PW-1:0] rs_pfn;
    logic fl_en = 0, fl_writable = 0, fl_wired = 0;
    logic [VW-1:0] fl_vpn = '0;
    logic [AW-1:0] fl_asid = '0;
    logic [PW-1:0] fl_pfn = '0;
    logic inv_all = 0, inv_asid_en = 0;
    logic [AW-1:0] inv_asid = '0;

    int total = 0, bad = 0;
    bit done = 0, seen_edge = 0;
    string cur_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_asid(lk_asid), .lk_write(lk_write), .rs_valid(rs_valid),
        .rs_hit(rs_hit), .rs_pfn(rs_pfn), .rs_writable(rs_writable),
        .rs_fault(rs_fault), .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_asid(fl_asid),
        .fl_pfn(fl_pfn), .fl_writable(fl_writable), .fl_wired(fl_wired),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid)
    );

    // Behavioural model state
    bit m_val[N], m_wir[N], m_wr[N];
    int m_vpn[N], m_asid[N], m_pfn[N];
    int m_rr;
    bit e_valid, e_hit, e_wr, e_fault;
    int e_pfn;

    // Model update on each edge
    always @(posedge clk) begin
        int h, v;
        seen_edge = 1;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_val[i] = 0; m_wir[i] = 0; end
            m_rr = 0;
            e_valid = 0; e_hit = 0; e_pfn = 0; e_wr = 0; e_fault = 0;
        end else begin
            h = -1;
            for (int i = 0; i < N; i++)
                if (m_val[i] && m_vpn[i] == int'(lk_vpn) && m_asid[i] == int'(lk_asid)) h = i;
            e_valid = lk_req;
            e_hit   = lk_req && h >= 0;
            e_pfn   = e_hit ? m_pfn[h] : 0;
            e_wr    = e_hit ? m_wr[h] : 0;
            e_fault = e_hit && lk_write && !m_wr[h];
            if (inv_all) begin
                for (int i = 0; i < N; i++) if (!m_wir[i]) m_val[i] = 0;
            end else if (inv_asid_en) begin
                for (int i = 0; i < N; i++)
                    if (!m_wir[i] && m_asid[i] == int'(inv_asid)) m_val[i] = 0;
            end else if (fl_en) begin
                v = -1;
                for (int i = 0; i < N; i++)
                    if (m_val[i] && m_vpn[i] == int'(fl_vpn) && m_asid[i] == int'(fl_asid)) v = i;
                if (v < 0) begin
                    for (int i = N - 1; i >= 0; i--) if (!m_val[i]) v = i;
                end
                if (v < 0) begin
                    for (int k = 0; k < N && v < 0; k++)
                        if (!m_wir[(m_rr + k) % N]) v = (m_rr + k) % N;
                    if (v >= 0) m_rr = (v + 1) % N;
                end
                if (v >= 0) begin
                    m_val[v] = 1; m_wir[v] = fl_wired; m_wr[v] = fl_writable;
                    m_vpn[v] = int'(fl_vpn); m_asid[v] = int'(fl_asid); m_pfn[v] = int'(fl_pfn);
                end
            end
        end
    end

    // Compare DUT against the model every cycle
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            total++;
            if (rs_valid !== e_valid || rs_hit !== e_hit || int'(rs_pfn) != e_pfn ||
                rs_writable !== e_wr || rs_fault !== e_fault) begin
                bad++;
                $display("FAIL %s model: got v=%0b h=%0b pfn=%0h w=%0b f=%0b expected v=%0b h=%0b pfn=%0h w=%0b f=%0b",
                         cur_tag, rs_valid, rs_hit, rs_pfn, rs_writable, rs_fault,
                         e_valid, e_hit, e_pfn, e_wr, e_fault);
            end
        end
    end

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic fill(input int vpn, input int asid, input int pfn, input bit wr, input bit wired);
        fl_vpn = VW'(vpn); fl_asid = AW'(asid); fl_pfn = PW'(pfn);
        fl_writable = wr; fl_wired = wired; fl_en = 1;
        @(negedge clk);
        fl_en = 0;
    endtask

    task automatic check_lookup(input int vpn, input int asid, input bit wr,
                                input bit x_hit, input int x_pfn, input bit x_fault, input string tag);
        lk_vpn = VW'(vpn); lk_asid = AW'(asid); lk_write = wr; lk_req = 1;
        @(negedge clk);
        lk_req = 0; lk_write = 0;
        total++;
        if (rs_valid !== 1'b1 || rs_hit !== x_hit || int'(rs_pfn) != x_pfn || rs_fault !== x_fault) begin
            bad++;
            $display("FAIL %s lookup %0h/%0h: got v=%0b h=%0b pfn=%0h f=%0b expected v=1 h=%0b pfn=%0h f=%0b",
                     tag, vpn, asid, rs_valid, rs_hit, rs_pfn, rs_fault, x_hit, x_pfn, x_fault);
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL R1 watchdog: done=0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        cur_tag = "R10";
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        total++;
        if (rs_valid !== 0 || rs_hit !== 0 || rs_pfn !== '0 || rs_fault !== 0) begin
            bad++;
            $display("FAIL R10 reset outputs: got v=%0b h=%0b pfn=%0h f=%0b expected all 0",
                     rs_valid, rs_hit, rs_pfn, rs_fault);
        end
        rst_n = 1;
        check_lookup(5, 1, 0, 0, 0, 0, "R10 empty after reset");

        // R2 basic hits and tag qualification
        cur_tag = "R2";
        fill(5, 1, 'h55, 0, 0);
        fill(6, 1, 'h66, 1, 0);
        check_lookup(5, 1, 0, 1, 'h55, 0, "R2 hit");
        check_lookup(5, 2, 0, 0, 0, 0, "R2 other asid misses");
        check_lookup(7, 1, 0, 0, 0, 0, "R2 other vpn misses");

        // R3 protection
        cur_tag = "R3";
        check_lookup(5, 1, 1, 1, 'h55, 1, "R3 write to read-only faults");
        check_lookup(6, 1, 1, 1, 'h66, 0, "R3 write to writable ok");
        check_lookup(7, 1, 1, 0, 0, 0, "R3 miss never faults");

        // R1 lookup races a fill of the same key
        cur_tag = "R1";
        lk_vpn = 7; lk_asid = 1; lk_req = 1;
        fl_vpn = 7; fl_asid = 1; fl_pfn = 'h77; fl_writable = 1; fl_wired = 0; fl_en = 1;
        @(negedge clk);
        lk_req = 0; fl_en = 0;
        total++;
        if (rs_valid !== 1 || rs_hit !== 0) begin
            bad++;
            $display("FAIL R1 racing lookup: got v=%0b h=%0b expected v=1 h=0", rs_valid, rs_hit);
        end
        check_lookup(7, 1, 0, 1, 'h77, 0, "R1 next lookup sees fill");

        // R4 in-place rewrite
        cur_tag = "R4";
        fill(5, 1, 'h5a, 1, 0);
        check_lookup(5, 1, 1, 1, 'h5a, 0, "R4 rewritten entry");
        check_lookup(6, 1, 0, 1, 'h66, 0, "R4 neighbour intact");

        // R8 per-tag flush
        cur_tag = "R8";
        fill(9, 2, 'h99, 0, 0);
        fill(8, 1, 'h88, 0, 1);
        inv_asid = 1; inv_asid_en = 1; @(negedge clk); inv_asid_en = 0;
        check_lookup(5, 1, 0, 0, 0, 0, "R8 tag 1 flushed");
        check_lookup(9, 2, 0, 1, 'h99, 0, "R8 tag 2 kept");
        check_lookup(8, 1, 0, 1, 'h88, 0, "R8 pinned kept");

        // R7 full flush
        cur_tag = "R7";
        inv_all = 1; @(negedge clk); inv_all = 0;
        check_lookup(9, 2, 0, 0, 0, 0, "R7 unpinned flushed");
        check_lookup(8, 1, 0, 1, 'h88, 0, "R7 pinned kept");

        // R9 fill with a flush is dropped
        cur_tag = "R9";
        fl_vpn = 12; fl_asid = 3; fl_pfn = 'hc; fl_writable = 0; fl_wired = 0; fl_en = 1;
        inv_all = 1; @(negedge clk); inv_all = 0;
        inv_asid = 7; inv_asid_en = 1; @(negedge clk); inv_asid_en = 0; fl_en = 0;
        check_lookup(12, 3, 0, 0, 0, 0, "R9 fill dropped");

        // R5 free slot before rotation
        cur_tag = "R5";
        do_reset();
        for (int i = 0; i < N; i++) fill(i, (i == 5) ? 2 : 1, 'h100 + i, 0, 0);
        inv_asid = 2; inv_asid_en = 1; @(negedge clk); inv_asid_en = 0;
        fill(30, 1, 'h130, 0, 0);
        fill(31, 1, 'h131, 0, 0);
        check_lookup(30, 1, 0, 1, 'h130, 0, "R5 hole reused");
        check_lookup(0, 1, 0, 0, 0, 0, "R5 then rotation evicts entry 0");
        check_lookup(1, 1, 0, 1, 'h101, 0, "R5 entry 1 kept");

        // R6 rotation skips pinned entries
        cur_tag = "R6";
        do_reset();
        for (int i = 0; i < 4; i++) fill(i, 0, 'h200 + i, 0, 1);
        for (int i = 16; i < 28; i++) fill(i, 0, 'h200 + i, 0, 0);
        fill(100, 0, 'h300, 0, 0);
        check_lookup(16, 0, 0, 0, 0, 0, "R6 first unpinned evicted");
        check_lookup(100, 0, 0, 1, 'h300, 0, "R6 new entry");
        check_lookup(0, 0, 0, 1, 'h200, 0, "R6 pinned kept");
        fill(101, 0, 'h301, 0, 0);
        check_lookup(17, 0, 0, 0, 0, 0, "R6 pointer advanced");
        check_lookup(18, 0, 0, 1, 'h212, 0, "R6 next kept");

        // R6 all pinned drops fill
        do_reset();
        for (int i = 0; i < N; i++) fill(i, 4, 'h400 + i, 1, 1);
        fill(50, 4, 'h450, 1, 0);
        check_lookup(50, 4, 0, 0, 0, 0, "R6 all pinned drops");
        check_lookup(15, 4, 0, 1, 'h40f, 0, "R6 pinned intact");

        // Random phase, model compares every cycle (R1 R2 R3 R4 R5 R6 R7 R8 R9 R11)
        cur_tag = "R11 random";
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            lk_req = ($urandom % 10) < 6;
            lk_vpn = VW'($urandom % 8); lk_asid = AW'($urandom % 3);
            lk_write = $urandom % 2;
            fl_en = ($urandom % 10) < 4;
            fl_vpn = VW'($urandom % 8); fl_asid = AW'($urandom % 3);
            fl_pfn = PW'($urandom % 4096); fl_writable = $urandom % 2;
            fl_wired = ($urandom % 10) == 0;
            inv_all = ($urandom % 50) == 0;
            inv_asid_en = ($urandom % 25) == 0;
            inv_asid = AW'($urandom % 3);
            @(negedge clk);
        end
        lk_req = 0; fl_en = 0; inv_all = 0; inv_asid_en = 0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule